// File: doc/BRIEF.md
# Chip Reset Sequencing Controller

This controller brings a chip out of reset in a fixed order. A power-on reset and a low level on the shared reset pad both enter the same flow at its first state. The flow first pulls the pad low and switches on the clock-generator enable. It then turns on the system, flash and bus clock enables. Next it lets the flash controller out of reset and fetches one option byte from non-volatile memory. It keeps the pad low until the flash reports that initialisation is complete. After that it stops pulling the pad and waits until the pad reads high. Only then does it enable the core clock and release system reset.

Because the pad is open-drain and shared, an external device can keep it low after the controller lets go, and system reset lasts for as long as the pad is held. The pad is sampled through a two-flop synchronizer and a low-level filter. A pulse that is too short to count as a reset is ignored. A pulse that is long enough, seen while the chip runs, restarts the whole sequence. The controller records whether the last reset came from power-on or from the pad.

The states are HOLD, CLKON, FLASH, PADWAIT and RUN, with these transitions:
- HOLD→CLKON after one cycle.
- CLKON→FLASH after one cycle.
- FLASH→PADWAIT once flash initialisation is done and the option byte is captured.
- PADWAIT→RUN once the filtered pad reads high.
- RUN→HOLD on a filtered pad assertion.
- Any state→HOLD on power-on reset.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_n` is low, these outputs are low: `sys_rst_n`, `flash_rst_n`, `sysclk_en`, `flashclk_en`, `busclk_en` and `core_clk_en`. At the same time `pad_oe` and `clkgen_en` are high, `opt_byte` reads 0xFF and `last_rst_pin` reads 0.
- R2: One cycle after the sequence leaves HOLD, `sysclk_en`, `flashclk_en` and every bit of `busclk_en` are 1, while `flash_rst_n` is still 0.
- R3: One cycle later `flash_rst_n` goes to 1, while `sys_rst_n` stays 0 and `pad_oe` stays 1.
- R4: While the flash is being initialised, `nvm_rd_req` is held high with `nvm_addr` equal to `OPT_ADDR` until `nvm_rd_valid` arrives. The returned `nvm_rd_data` then appears on `opt_byte`. The byte is fetched again on every sequence, and power-on reset sets it back to 0xFF.
- R5: `pad_oe` stays 1 until `flash_done` is high and the option byte has been captured. It falls in the following cycle.
- R6: While the filtered pad reads low after `pad_oe` has fallen, `sys_rst_n` and `core_clk_en` stay 0.
- R7: `core_clk_en` and `sys_rst_n` rise in the same cycle, once the filtered pad reads high. At that point `pad_oe` is 0.
- R8: A low pad level lasting fewer than `FILT_CYCLES` clocks is ignored while running. A low level lasting `FILT_CYCLES` clocks or more restarts the sequence.
- R9: A pad restart re-runs the whole sequence from HOLD, including the flash reset and the option-byte fetch.
- R10: `pad_do` is always 0, so the pad is only ever pulled low.
- R11: `last_rst_pin` becomes 1 after a pad-triggered restart. It stays 1 until the next power-on reset clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pad_in | input | 1 | Sensed level of the shared reset pad |
| pad_oe | output | 1 | Pad output enable (1 pulls the pad low) |
| pad_do | output | 1 | Pad output data, always 0 |
| clkgen_en | output | 1 | Clock generator enable, default mode |
| sysclk_en | output | 1 | System clock enable |
| flashclk_en | output | 1 | Flash clock enable |
| busclk_en | output | NUM_BUS | Enables for bus clocks that have no separate gate |
| core_clk_en | output | 1 | Core clock enable |
| flash_rst_n | output | 1 | Flash controller reset, active low |
| flash_done | input | 1 | Flash initialisation complete |
| nvm_rd_req | output | 1 | Option-byte read request |
| nvm_addr | output | NVM_AW | Option-byte address |
| nvm_rd_valid | input | 1 | Read data valid |
| nvm_rd_data | input | 8 | Read data |
| opt_byte | output | 8 | Latched option byte |
| last_rst_pin | output | 1 | 1 if the last reset came from the pad |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The assertions assume three things about the environment. First, `flash_done` stays high from the moment it is raised until the flash controller is put back into reset. Second, the memory returns exactly one `nvm_rd_valid` pulse for each request. Third, `por_n` is the only asynchronous event.

The bench's flash model holds done until `flash_rst_n` falls, and its memory model answers each request once after a fixed delay. The bench only moves the external pad hold and `por_n` on falling clock edges. This keeps every pad pulse a whole number of cycles long, so pulses sit exactly at or just below the filter length.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD    = 3'd0,
        ST_CLKON   = 3'd1,
        ST_FLASH   = 3'd2,
        ST_PADWAIT = 3'd3,
        ST_RUN     = 3'd4
    } rst_state_e;

    localparam int OPT_W = 8;

endpackage

// File: rtl/rst_pad_filter.sv
module rst_pad_filter #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic pad_in,
    output logic pad_low
);
    localparam int CW = $clog2(FILT_CYCLES + 1);

    logic          sync1_q;
    logic          sync2_q;
    logic [CW-1:0] low_cnt_q;

    // two-flop synchronizer, idle level high
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= pad_in;
            sync2_q <= sync1_q;
        end
    end

    // count consecutive low samples, saturating at the filter length;
    // a single high sample clears the count at once
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            low_cnt_q <= '0;
        end else if (sync2_q) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != CW'(FILT_CYCLES)) begin
            low_cnt_q <= low_cnt_q + CW'(1);
        end
    end

    assign pad_low = (low_cnt_q == CW'(FILT_CYCLES));

endmodule

// File: rtl/rst_opt_capture.sv
module rst_opt_capture #(
    parameter int                 NVM_AW   = 10,
    parameter logic [NVM_AW-1:0]  OPT_ADDR = '0
) (
    input  logic                          clk,
    input  logic                          por_n,
    input  logic                          clear,
    input  logic                          active,
    output logic                          nvm_rd_req,
    output logic [NVM_AW-1:0]             nvm_addr,
    input  logic                          nvm_rd_valid,
    input  logic [rstseq_pkg::OPT_W-1:0]  nvm_rd_data,
    output logic [rstseq_pkg::OPT_W-1:0]  opt_byte,
    output logic                          got
);
    logic                         got_q;
    logic [rstseq_pkg::OPT_W-1:0] opt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            got_q <= 1'b0;
            opt_q <= '1;
        end else if (clear) begin
            got_q <= 1'b0;
        end else if (active && !got_q && nvm_rd_valid) begin
            got_q <= 1'b1;
            opt_q <= nvm_rd_data;
        end
    end

    assign nvm_rd_req = active && !got_q;
    assign nvm_addr   = OPT_ADDR;
    assign opt_byte   = opt_q;
    assign got        = got_q;

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rstseq_pkg::*;
#(
    parameter int NUM_BUS = 2
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               pad_low,
    input  logic               flash_done,
    input  logic               opt_got,
    output logic               pad_oe,
    output logic               clkgen_en,
    output logic               sysclk_en,
    output logic               flashclk_en,
    output logic [NUM_BUS-1:0] busclk_en,
    output logic               core_clk_en,
    output logic               flash_rst_n,
    output logic               sys_rst_n,
    output logic               opt_clear,
    output logic               opt_active,
    output logic               last_rst_pin
);
    rst_state_e state_q;
    rst_state_e state_d;
    logic       last_pin_q;
    logic       clk_on;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    state_d = ST_CLKON;
            ST_CLKON:   state_d = ST_FLASH;
            ST_FLASH:   if (flash_done && opt_got) state_d = ST_PADWAIT;
            ST_PADWAIT: if (!pad_low)              state_d = ST_RUN;
            ST_RUN:     if (pad_low)               state_d = ST_HOLD;
            default:    state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // reset-source record, cleared only by power-on
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                         last_pin_q <= 1'b0;
        else if (state_q == ST_RUN && pad_low) last_pin_q <= 1'b1;
    end

    // outputs decoded from the state
    always_comb begin
        pad_oe      = 1'b1;
        clkgen_en   = 1'b1;
        clk_on      = 1'b0;
        core_clk_en = 1'b0;
        flash_rst_n = 1'b0;
        sys_rst_n   = 1'b0;
        opt_clear   = 1'b0;
        opt_active  = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                opt_clear = 1'b1;
            end
            ST_CLKON: begin
                clk_on = 1'b1;
            end
            ST_FLASH: begin
                clk_on      = 1'b1;
                flash_rst_n = 1'b1;
                opt_active  = 1'b1;
            end
            ST_PADWAIT: begin
                pad_oe      = 1'b0;
                clk_on      = 1'b1;
                flash_rst_n = 1'b1;
            end
            ST_RUN: begin
                pad_oe      = 1'b0;
                clk_on      = 1'b1;
                flash_rst_n = 1'b1;
                core_clk_en = 1'b1;
                sys_rst_n   = 1'b1;
            end
            default: begin
                opt_clear = 1'b1;
            end
        endcase
    end

    assign sysclk_en   = clk_on;
    assign flashclk_en = clk_on;

    for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus_en
        assign busclk_en[g] = clk_on;
    end

    assign last_rst_pin = last_pin_q;

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
    parameter int                FILT_CYCLES = 4,
    parameter int                NUM_BUS     = 2,
    parameter int                NVM_AW      = 10,
    parameter logic [NVM_AW-1:0] OPT_ADDR    = 10'h00D
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               pad_in,
    output logic               pad_oe,
    output logic               pad_do,
    output logic               clkgen_en,
    output logic               sysclk_en,
    output logic               flashclk_en,
    output logic [NUM_BUS-1:0] busclk_en,
    output logic               core_clk_en,
    output logic               flash_rst_n,
    input  logic               flash_done,
    output logic               nvm_rd_req,
    output logic [NVM_AW-1:0]  nvm_addr,
    input  logic               nvm_rd_valid,
    input  logic [7:0]         nvm_rd_data,
    output logic [7:0]         opt_byte,
    output logic               last_rst_pin,
    output logic               sys_rst_n
);
    logic pad_low;
    logic opt_got;
    logic opt_clear;
    logic opt_active;

    rst_pad_filter #(
        .FILT_CYCLES (FILT_CYCLES)
    ) i_filter (
        .clk     (clk),
        .por_n   (por_n),
        .pad_in  (pad_in),
        .pad_low (pad_low)
    );

    rst_opt_capture #(
        .NVM_AW   (NVM_AW),
        .OPT_ADDR (OPT_ADDR)
    ) i_opt (
        .clk          (clk),
        .por_n        (por_n),
        .clear        (opt_clear),
        .active       (opt_active),
        .nvm_rd_req   (nvm_rd_req),
        .nvm_addr     (nvm_addr),
        .nvm_rd_valid (nvm_rd_valid),
        .nvm_rd_data  (nvm_rd_data),
        .opt_byte     (opt_byte),
        .got          (opt_got)
    );

    rst_seq_fsm #(
        .NUM_BUS (NUM_BUS)
    ) i_fsm (
        .clk          (clk),
        .por_n        (por_n),
        .pad_low      (pad_low),
        .flash_done   (flash_done),
        .opt_got      (opt_got),
        .pad_oe       (pad_oe),
        .clkgen_en    (clkgen_en),
        .sysclk_en    (sysclk_en),
        .flashclk_en  (flashclk_en),
        .busclk_en    (busclk_en),
        .core_clk_en  (core_clk_en),
        .flash_rst_n  (flash_rst_n),
        .sys_rst_n    (sys_rst_n),
        .opt_clear    (opt_clear),
        .opt_active   (opt_active),
        .last_rst_pin (last_rst_pin)
    );

    // open-drain pad: only ever pulled low
    assign pad_do = 1'b0;

endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
    parameter int NVM_AW = 10
) (
    input logic              clk,
    input logic              por_n,
    input logic              pad_oe,
    input logic              sysclk_en,
    input logic              flashclk_en,
    input logic              core_clk_en,
    input logic              flash_rst_n,
    input logic              flash_done,
    input logic              nvm_rd_req,
    input logic [NVM_AW-1:0] nvm_addr,
    input logic              nvm_rd_valid,
    input logic              last_rst_pin,
    input logic              sys_rst_n
);
    // flash is only out of reset with its clocks running
    assert_flash_clocked_R3: assert property (@(posedge clk) disable iff (!por_n)
        (flash_rst_n && !sys_rst_n) |-> (sysclk_en && flashclk_en));

    // an open read request is held with a steady address until answered
    assert_opt_req_held_R4: assert property (@(posedge clk) disable iff (!por_n)
        (nvm_rd_req && !nvm_rd_valid) |=> (nvm_rd_req && $stable(nvm_addr)));

    // the pad is let go only after flash reported done
    assert_pad_release_after_done_R5: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pad_oe) |-> $past(flash_done));

    // no core clock while system reset is held
    assert_core_off_in_reset_R6: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |-> !core_clk_en);

    // system reset release comes with the core clock and a released pad
    assert_release_together_R7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_n) |-> (core_clk_en && !pad_oe));

    // the pad-source flag is sticky until power-on reset
    assert_source_sticky_R11: assert property (@(posedge clk) disable iff (!por_n)
        $past(last_rst_pin) |-> last_rst_pin);

endmodule

bind rst_sequencer rst_sequencer_chk #(
    .NVM_AW (NVM_AW)
) i_chk (
    .clk          (clk),
    .por_n        (por_n),
    .pad_oe       (pad_oe),
    .sysclk_en    (sysclk_en),
    .flashclk_en  (flashclk_en),
    .core_clk_en  (core_clk_en),
    .flash_rst_n  (flash_rst_n),
    .flash_done   (flash_done),
    .nvm_rd_req   (nvm_rd_req),
    .nvm_addr     (nvm_addr),
    .nvm_rd_valid (nvm_rd_valid),
    .last_rst_pin (last_rst_pin),
    .sys_rst_n    (sys_rst_n)
);

// File: tb/test_rst_sequencer.sv
`timescale 1ns/1ps
module test_rst_sequencer;
    localparam int CLK_PERIOD = 20;
    localparam int FILT       = 4;
    localparam int NBUS       = 2;
    localparam int AW         = 10;
    localparam logic [AW-1:0] OPTA = 10'h00D;

    logic            clk = 1'b0;
    logic            por_n;
    logic            pad_in;
    logic            pad_oe, pad_do, clkgen_en, sysclk_en, flashclk_en;
    logic [NBUS-1:0] busclk_en;
    logic            core_clk_en, flash_rst_n, sys_rst_n, last_rst_pin;
    logic            flash_done = 1'b0;
    logic            nvm_rd_req, nvm_rd_valid = 1'b0;
    logic [AW-1:0]   nvm_addr;
    logic [7:0]      nvm_rd_data = 8'h00, opt_byte;
    logic            ext_low = 1'b0;
    logic [7:0]      nvm_value = 8'h00;

    typedef struct packed { logic [7:0] opt; logic pin; } exp_t;
    exp_t exp_q[$];

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // shared open-drain pad: low if the block pulls it or the board holds it
    assign pad_in = (pad_oe ? pad_do : 1'b1) & ~ext_low;

    rst_sequencer #(
        .FILT_CYCLES (FILT), .NUM_BUS (NBUS), .NVM_AW (AW), .OPT_ADDR (OPTA)
    ) i_rst_sequencer (
        .clk (clk), .por_n (por_n), .pad_in (pad_in), .pad_oe (pad_oe),
        .pad_do (pad_do), .clkgen_en (clkgen_en), .sysclk_en (sysclk_en),
        .flashclk_en (flashclk_en), .busclk_en (busclk_en),
        .core_clk_en (core_clk_en), .flash_rst_n (flash_rst_n),
        .flash_done (flash_done), .nvm_rd_req (nvm_rd_req),
        .nvm_addr (nvm_addr), .nvm_rd_valid (nvm_rd_valid),
        .nvm_rd_data (nvm_rd_data), .opt_byte (opt_byte),
        .last_rst_pin (last_rst_pin), .sys_rst_n (sys_rst_n)
    );

    // flash model: done 13 cycles after its reset is lifted
    int fcnt = 0;
    always @(posedge clk) begin
        if (!flash_rst_n) begin
            fcnt <= 0; flash_done <= 1'b0;
        end else if (fcnt == 12) flash_done <= 1'b1;
        else fcnt <= fcnt + 1;
    end

    // memory model: one answer per request after a short delay
    int dly = 0;
    always @(posedge clk) begin
        nvm_rd_valid <= 1'b0;
        if (nvm_rd_req && !nvm_rd_valid) begin
            if (dly == 2) begin
                nvm_rd_valid <= 1'b1; nvm_rd_data <= nvm_value; dly <= 0;
            end else dly <= dly + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_release(input logic [7:0] opt, input logic pin);
        exp_t e;
        e.opt = opt; e.pin = pin;
        exp_q.push_back(e);
    endtask

    // monitor: each system reset release is compared with the queue head
    logic prev_rst = 1'b0;
    always @(negedge clk) begin
        if (sys_rst_n && !prev_rst) begin
            if (exp_q.size() == 0) chk("R7", "unexpected release", 1, 0);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R4", "opt_byte at release", {24'd0, opt_byte}, {24'd0, e.opt});
                chk("R11", "last_rst_pin at release", {31'd0, last_rst_pin}, {31'd0, e.pin});
                chk("R7", "core_clk_en with release", {31'd0, core_clk_en}, 1);
                chk("R7", "pad_oe at release", {31'd0, pad_oe}, 0);
            end
        end
        prev_rst = sys_rst_n;
    end

    task automatic wait_release();
        for (int i = 0; i < 200 && !sys_rst_n; i++) @(negedge clk);
        chk("R7", "sys_rst_n released", {31'd0, sys_rst_n}, 1);
    endtask

    task automatic pin_pulse(input int cycles);
        ext_low = 1'b1;
        repeat (cycles) @(negedge clk);
        ext_low = 1'b0;
    endtask

    task automatic expect_restart();
        bit fell = 1'b0;
        bit flash_reset = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!sys_rst_n) fell = 1'b1;
            if (!flash_rst_n) flash_reset = 1'b1;
        end
        chk("R8", "restart after full-length pulse", {31'd0, fell}, 1);
        chk("R9", "flash put back in reset", {31'd0, flash_reset}, 1);
    endtask

    initial begin
        por_n = 1'b0;
        nvm_value = 8'hA5;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "pad_oe", {31'd0, pad_oe}, 1);
        chk("R1", "sys_rst_n", {31'd0, sys_rst_n}, 0);
        chk("R1", "flash_rst_n", {31'd0, flash_rst_n}, 0);
        chk("R1", "clocks", {28'd0, sysclk_en, flashclk_en, core_clk_en, |busclk_en}, 0);
        chk("R1", "clkgen_en", {31'd0, clkgen_en}, 1);
        chk("R1", "opt_byte", {24'd0, opt_byte}, 32'hFF);
        chk("R1", "last_rst_pin", {31'd0, last_rst_pin}, 0);
        chk("R10", "pad_do", {31'd0, pad_do}, 0);

        // first sequence, board holds the pad low to stretch reset
        expect_release(8'hA5, 1'b0);
        ext_low = 1'b1;
        por_n = 1'b1;
        @(negedge clk);
        chk("R2", "clock enables on", {29'd0, sysclk_en, flashclk_en, &busclk_en}, 32'h7);
        chk("R2", "flash still in reset", {31'd0, flash_rst_n}, 0);
        @(negedge clk);
        chk("R3", "flash released", {31'd0, flash_rst_n}, 1);
        chk("R3", "system held", {31'd0, sys_rst_n}, 0);
        chk("R3", "pad pulled", {31'd0, pad_oe}, 1);
        chk("R4", "read request", {31'd0, nvm_rd_req}, 1);
        chk("R4", "read address", {22'd0, nvm_addr}, {22'd0, OPTA});
        for (int i = 0; i < 100 && !flash_done; i++) begin
            chk("R5", "pad pulled before done", {31'd0, pad_oe}, 1);
            @(negedge clk);
        end
        @(negedge clk);
        chk("R5", "pad let go after done", {31'd0, pad_oe}, 0);
        repeat (20) @(negedge clk);
        chk("R6", "system held by board", {31'd0, sys_rst_n}, 0);
        chk("R6", "core clock off", {31'd0, core_clk_en}, 0);
        ext_low = 1'b0;
        wait_release();
        repeat (4) @(negedge clk);

        // glitch one cycle shorter than the filter
        pin_pulse(FILT - 1);
        begin
            bit stayed = 1'b1;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (!sys_rst_n) stayed = 1'b0;
            end
            chk("R8", "short pulse ignored", {31'd0, stayed}, 1);
        end
        chk("R11", "source after glitch", {31'd0, last_rst_pin}, 0);

        // full-length pulse restarts
        nvm_value = 8'h3C;
        expect_release(8'h3C, 1'b1);
        pin_pulse(FILT);
        expect_restart();
        chk("R11", "pad source recorded", {31'd0, last_rst_pin}, 1);
        wait_release();
        repeat (4) @(negedge clk);

        // long board hold restarts and stretches
        nvm_value = 8'h5A;
        expect_release(8'h5A, 1'b1);
        ext_low = 1'b1;
        repeat (60) @(negedge clk);
        chk("R6", "held through long pulse", {31'd0, sys_rst_n}, 0);
        ext_low = 1'b0;
        wait_release();
        chk("R10", "pad_do", {31'd0, pad_do}, 0);

        // power-on reset clears the record
        por_n = 1'b0;
        @(negedge clk);
        chk("R11", "cleared by power-on", {31'd0, last_rst_pin}, 0);
        chk("R4", "option reset to FF", {24'd0, opt_byte}, 32'hFF);
        nvm_value = 8'hC3;
        expect_release(8'hC3, 1'b0);
        @(negedge clk);
        por_n = 1'b1;
        wait_release();
        repeat (2) @(negedge clk);
        chk("R9", "all releases seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R9 watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule